// File: doc/BRIEF.md
# Coprocessor Bus Acknowledge Responder

This block is the slave-side acknowledge logic of a coprocessor on an asynchronous host bus whose port width can change from one cycle to the next. It watches the active-low chip select, address strobe and data strobe and the read/write line. It also watches address bit A4 and a static width setting. From these it drives a two-bit active-low acknowledge pair. Each bit has an output enable that stands in for a three-state pin. The pattern of the pair tells the host how wide the port is for the current cycle. On a 32-bit bus, an access with A4 low targets a 16-bit register that lives on the upper data lanes, so the responder reports a 16-bit port for that access. While both lines are driven high, the host keeps inserting wait states.

All asynchronous controls pass through a two-flop synchronizer. A cycle opens when the synchronized chip select and address strobe are both low. The responder then holds the wait pattern for a programmable count of clocks. A write also has to wait for the data strobe before it is acknowledged. When either strobe rises, the responder drives both lines high for one clock and then releases them. The same active-low reset returns the acknowledge logic to idle. It also initialises a small register file: data registers are loaded with a quiet not-a-number and the control, status and instruction-address registers are cleared.

Top module: `cop_ack_responder`

## Requirements
- R1: Both output enables always carry the same value. After reset, and between bus cycles, both are 0.
- R2: A cycle begins in the third rising clock edge after chip select and address strobe are both low at the pins, because the two-flop synchronizer adds two edges. From that edge both enables are 1.
- R3: The acknowledge pattern {ack_n[1], ack_n[0]} reports the port width: 00 for 32-bit, 10 for 16-bit, 01 for 8-bit. The width_cfg code is 00 for 8-bit, 01 for 16-bit, and 10 or 11 for 32-bit.
- R4: On a 32-bit bus with A4 at 0, the pattern is 10, which marks a 16-bit register on the upper lanes.
- R5: With wait_cfg = N, the pattern 11 (wait) is driven for exactly N clocks before the width pattern. With N = 0 the width pattern appears in the start clock.
- R6: The width pattern holds until a synchronized rising edge of address strobe or data strobe. Such a rising edge ends the cycle even while it is still in its wait phase.
- R7: After the end of a cycle, both lines are driven to 11 for exactly one clock. Both enables then fall to 0.
- R8: While rst_n is low at a clock edge, every data register becomes 32'h7FC0_0000. Control (address 8), status (address 9) and instruction address (address 10) become 0.
- R9: A write with rf_we high and rst_n high updates the addressed register at the clock edge. rf_rdata shows the register at rf_raddr. Any address above 10 reads 0.
- R10: On a write cycle (rw = 0), no width pattern is given until the synchronized data strobe is low. A read (rw = 1) does not wait for the data strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled at the clock edge |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| rw | input | 1 | 1 = host read, 0 = host write |
| a4 | input | 1 | Address bit 4 |
| width_cfg | input | 2 | Static bus width setting (00 = 8, 01 = 16, 1x = 32) |
| wait_cfg | input | 3 | Wait clocks before acknowledge (0 to 7) |
| ack_n | output | 2 | Active-low acknowledge pair {bit1, bit0} |
| ack_oe | output | 2 | Output enable per acknowledge bit |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 4 | Register file write address |
| rf_wdata | input | 32 | Register file write data |
| rf_raddr | input | 4 | Register file read address |
| rf_rdata | output | 32 | Register file read data |

## Verification
The sequencer's internal state has a direct signature at the pins. A wrong state shows as an enable pair that rises or falls at the wrong edge, or as a width pattern that appears early, late or with the wrong code. The wait counter is one example: an error there moves the first non-11 pattern by one clock or more. A missed strobe edge leaves the pattern held past the point where the one-clock drive-high should start. The bench's model predicts both pins on every clock, so any such slip is reported in the clock where it first appears. Register file corruption shows the next time that address is read back through the read port.

// File: rtl/cop_ack_pkg.sv
package cop_ack_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_DATA = 8;
    localparam int NUM_REGS = NUM_DATA + 3;
    localparam int RF_AW    = $clog2(NUM_REGS + 5);
    localparam int WAIT_W   = 3;
    localparam int SYNC_W   = 4;

    localparam logic [DATA_W-1:0] QUIET_NAN = 32'h7FC0_0000;

    localparam int CTRL_IDX   = NUM_DATA;
    localparam int STATUS_IDX = NUM_DATA + 1;
    localparam int IADDR_IDX  = NUM_DATA + 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ACK   = 2'd2,
        ST_DRVHI = 2'd3
    } ack_state_e;

    typedef struct packed {
        logic cs_n;
        logic as_n;
        logic ds_n;
        logic rw;
    } bus_ctl_t;

    localparam logic [1:0] CODE_WAIT = 2'b11;
    localparam logic [1:0] CODE_P32  = 2'b00;
    localparam logic [1:0] CODE_P16  = 2'b10;
    localparam logic [1:0] CODE_P8   = 2'b01;

    function automatic logic [1:0] port_code(input logic [1:0] width, input logic a4);
        logic [1:0] code;
        if (width == 2'b00)      code = CODE_P8;
        else if (width == 2'b01) code = CODE_P16;
        else if (a4)             code = CODE_P32;
        else                     code = CODE_P16;
        return code;
    endfunction

endpackage

// File: rtl/cop_sync.sv
module cop_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta, stab;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta <= RST_VAL[i];
                stab <= RST_VAL[i];
            end else begin
                meta <= d[i];
                stab <= meta;
            end
        end
        assign q[i] = stab;
    end
endmodule

// File: rtl/cop_ack_fsm.sv
module cop_ack_fsm
    import cop_ack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ctl_t          ctl_s,
    input  logic              a4,
    input  logic [1:0]        width_cfg,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic [1:0]        ack_n,
    output logic [1:0]        ack_oe
);
    ack_state_e        state;
    logic [WAIT_W-1:0] cnt;
    logic [WAIT_W-1:0] cnt_dec;
    logic [1:0]        code_q;
    logic              as_prev, ds_prev;
    logic              ready, cyc_end, start;

    assign ready   = ctl_s.rw | ~ctl_s.ds_n;
    assign cyc_end = (ctl_s.as_n & ~as_prev) | (ctl_s.ds_n & ~ds_prev);
    assign start   = ~ctl_s.cs_n & ~ctl_s.as_n;
    assign cnt_dec = (cnt != '0) ? cnt - 1'b1 : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            code_q  <= CODE_WAIT;
            as_prev <= 1'b1;
            ds_prev <= 1'b1;
        end else begin
            as_prev <= ctl_s.as_n;
            ds_prev <= ctl_s.ds_n;
            unique case (state)
                ST_IDLE: if (start) begin
                    code_q <= port_code(width_cfg, a4);
                    cnt    <= wait_cfg;
                    state  <= (wait_cfg == '0 && ready) ? ST_ACK : ST_WAIT;
                end
                ST_WAIT: begin
                    if (cyc_end) state <= ST_DRVHI;
                    else begin
                        cnt <= cnt_dec;
                        if (cnt_dec == '0 && ready) state <= ST_ACK;
                    end
                end
                ST_ACK:   if (cyc_end) state <= ST_DRVHI;
                ST_DRVHI: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ack_oe = (state == ST_IDLE) ? 2'b00 : 2'b11;
        ack_n  = (state == ST_ACK) ? code_q : CODE_WAIT;
    end

    // R7: enables fall only after a clock of driven-high lines
    a_r7_release_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_oe[0]) |-> $past(ack_n) == CODE_WAIT);

    // R6: width pattern stays constant while acknowledging
    a_r6_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && $past(state) == ST_ACK) |-> $stable(ack_n));

    // R2: leaving idle needs synchronized chip select and address strobe low
    a_r2_start_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IDLE && state != ST_IDLE) |-> $past(start));

    // R3: full-width pattern only on a 32-bit configuration
    a_r3_full_width_only_32: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_oe[0] && ack_n == CODE_P32) |-> width_cfg[1]);

    // R5: direct acknowledge from idle only with a zero wait count
    a_r5_no_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IDLE && state == ST_ACK) |-> $past(wait_cfg) == '0);

    // R10: a write reaches the acknowledge state only with data strobe low
    a_r10_write_needs_ds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_ACK && state == ST_ACK) |-> $past(ready));
endmodule

// File: rtl/cop_regfile.sv
module cop_regfile
    import cop_ack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RF_AW-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RF_AW-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [DATA_W-1:0] INIT = (i < NUM_DATA) ? QUIET_NAN : '0;
        always_ff @(posedge clk) begin
            if (!rst_n)                                  regs[i] <= INIT;
            else if (we && waddr == RF_AW'(i))           regs[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int j = 0; j < NUM_REGS; j++)
            if (raddr == RF_AW'(j)) rdata = regs[j];
    end

    // R8: one clock of reset leaves the control register cleared
    a_r8_ctrl_cleared: assert property (@(posedge clk)
        (!rst_n) |=> regs[CTRL_IDX] == '0);

    // R8: one clock of reset leaves data register 0 at the quiet NaN
    a_r8_data_qnan: assert property (@(posedge clk)
        (!rst_n) |=> regs[0] == QUIET_NAN);
endmodule

// File: rtl/cop_ack_responder.sv
module cop_ack_responder
    import cop_ack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic              a4,
    input  logic [1:0]        width_cfg,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic [1:0]        ack_n,
    output logic [1:0]        ack_oe,
    input  logic              rf_we,
    input  logic [RF_AW-1:0]  rf_waddr,
    input  logic [DATA_W-1:0] rf_wdata,
    input  logic [RF_AW-1:0]  rf_raddr,
    output logic [DATA_W-1:0] rf_rdata
);
    bus_ctl_t ctl_raw, ctl_s;

    assign ctl_raw = '{cs_n: cs_n, as_n: as_n, ds_n: ds_n, rw: rw};

    cop_sync #(.W(SYNC_W), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s)
    );

    cop_ack_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_s     (ctl_s),
        .a4        (a4),
        .width_cfg (width_cfg),
        .wait_cfg  (wait_cfg),
        .ack_n     (ack_n),
        .ack_oe    (ack_oe)
    );

    cop_regfile u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    // R1: enable pair always matches
    a_r1_enable_pair: assert property (@(posedge clk) disable iff (!rst_n)
        ack_oe[0] == ack_oe[1]);
endmodule

// File: tb/cop_ack_responder_tb.sv
module cop_ack_responder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, as_n = 1'b1, ds_n = 1'b1, rw = 1'b1, a4 = 1'b1;
    logic [1:0]  width_cfg = 2'b10;
    logic [2:0]  wait_cfg = 3'd0;
    logic [1:0]  ack_n, ack_oe;
    logic        rf_we = 1'b0;
    logic [3:0]  rf_waddr = '0, rf_raddr = '0;
    logic [31:0] rf_wdata = '0, rf_rdata;

    int checks = 0, fails = 0, cycles = 0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    cop_ack_responder u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .ds_n(ds_n), .rw(rw),
        .a4(a4), .width_cfg(width_cfg), .wait_cfg(wait_cfg), .ack_n(ack_n),
        .ack_oe(ack_oe), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
    );

    // behavioural reference: pin histories and a phase number
    int m_cs[$], m_as[$], m_ds[$], m_rw[$];
    int m_phase = 0;   // 0 released, 1 waiting, 2 acknowledging, 3 driving high
    int m_left = 0;
    int m_code = 3;
    int m_as_last = 1, m_ds_last = 1;

    function automatic int code_of(input int w, input int a);
        if (w == 0) return 1;
        if (w == 1) return 2;
        return (a != 0) ? 0 : 2;
    endfunction

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_cs.push_back(1); m_as.push_back(1); m_ds.push_back(1); m_rw.push_back(1);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cs = '{1, 1}; m_as = '{1, 1}; m_ds = '{1, 1}; m_rw = '{1, 1};
            m_phase = 0; m_left = 0; m_code = 3; m_as_last = 1; m_ds_last = 1;
        end else begin
            int cs_v, as_v, ds_v, rw_v, rdy, fin;
            cs_v = m_cs[0]; as_v = m_as[0]; ds_v = m_ds[0]; rw_v = m_rw[0];
            rdy = (rw_v == 1 || ds_v == 0) ? 1 : 0;
            fin = ((as_v == 1 && m_as_last == 0) || (ds_v == 1 && m_ds_last == 0)) ? 1 : 0;
            case (m_phase)
                0: if (cs_v == 0 && as_v == 0) begin
                    m_code = code_of(int'(width_cfg), int'(a4));
                    m_left = int'(wait_cfg);
                    m_phase = (m_left == 0 && rdy == 1) ? 2 : 1;
                end
                1: if (fin == 1) m_phase = 3;
                   else begin
                       if (m_left > 0) m_left--;
                       if (m_left == 0 && rdy == 1) m_phase = 2;
                   end
                2: if (fin == 1) m_phase = 3;
                default: m_phase = 0;
            endcase
            m_as_last = as_v; m_ds_last = ds_v;
            void'(m_cs.pop_front()); void'(m_as.pop_front());
            void'(m_ds.pop_front()); void'(m_rw.pop_front());
            m_cs.push_back(int'(cs_n)); m_as.push_back(int'(as_n));
            m_ds.push_back(int'(ds_n)); m_rw.push_back(int'(rw));
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // compare pins against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [1:0] e_oe, e_ack;
            e_oe  = (m_phase == 0) ? 2'b00 : 2'b11;
            e_ack = (m_phase == 2) ? 2'(m_code) : 2'b11;
            check({cur_tag, " oe"}, {30'd0, ack_oe}, {30'd0, e_oe});
            check({cur_tag, " ack"}, {30'd0, ack_n}, {30'd0, e_ack});
        end
    end

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic bus_cycle(input string tag, input logic [1:0] w, input logic a,
                             input logic r, input logic [2:0] wt,
                             input int ds_delay, input int hold);
        cur_tag = tag;
        width_cfg = w; a4 = a; rw = r; wait_cfg = wt;
        tick(1);
        cs_n = 1'b0; as_n = 1'b0;
        if (ds_delay == 0) ds_n = 1'b0;
        for (int k = 0; k < hold; k++) begin
            tick(1);
            if (k + 1 == ds_delay) ds_n = 1'b0;
        end
        as_n = 1'b1; ds_n = 1'b1; cs_n = 1'b1;
        tick(6);
    endtask

    initial begin
        // reset and register file reset values
        cur_tag = "R1";
        tick(5);
        for (int i = 0; i < 8; i++) begin
            rf_raddr = 4'(i); #1;
            check("R8 data reset", rf_rdata, 32'h7FC0_0000);
        end
        for (int i = 8; i < 11; i++) begin
            rf_raddr = 4'(i); #1;
            check("R8 ctrl/status/iaddr reset", rf_rdata, 32'h0);
        end
        rst_n = 1'b1;
        tick(2);
        check("R1 idle enables", {30'd0, ack_oe}, 32'd0);

        // register write and readback
        for (int i = 0; i < 11; i++) begin
            rf_we = 1'b1; rf_waddr = 4'(i); rf_wdata = 32'h1000 + 32'(i) * 32'h11;
            tick(1);
        end
        rf_we = 1'b0;
        for (int i = 0; i < 11; i++) begin
            rf_raddr = 4'(i); #1;
            check("R9 readback", rf_rdata, 32'h1000 + 32'(i) * 32'h11);
        end
        rf_raddr = 4'd15; #1;
        check("R9 unmapped", rf_rdata, 32'h0);

        // R2: exact start edge
        cur_tag = "R2";
        width_cfg = 2'b10; a4 = 1'b1; rw = 1'b1; wait_cfg = 3'd0;
        tick(1);
        cs_n = 1'b0; as_n = 1'b0; ds_n = 1'b0;
        tick(2);
        check("R2 still released after two edges", {30'd0, ack_oe}, 32'd0);
        tick(1);
        check("R2 driven after third edge", {30'd0, ack_oe}, 32'd3);
        check("R3 32-bit pattern", {30'd0, ack_n}, 32'd0);
        as_n = 1'b1; ds_n = 1'b1; cs_n = 1'b1;
        tick(3);
        check("R7 driving high", {30'd0, ack_oe, ack_n}, {28'd0, 4'b1111});
        tick(1);
        check("R7 released", {30'd0, ack_oe}, 32'd0);
        tick(4);

        bus_cycle("R3 32-bit a4=1", 2'b10, 1'b1, 1'b1, 3'd0, 0, 6);
        bus_cycle("R4 32-bit a4=0", 2'b10, 1'b0, 1'b1, 3'd0, 0, 6);
        bus_cycle("R3 16-bit", 2'b01, 1'b1, 1'b1, 3'd0, 0, 6);
        bus_cycle("R3 8-bit", 2'b00, 1'b0, 1'b1, 3'd0, 0, 6);
        bus_cycle("R3 width code 11", 2'b11, 1'b1, 1'b1, 3'd0, 0, 6);
        bus_cycle("R5 wait 3", 2'b10, 1'b1, 1'b1, 3'd3, 0, 9);
        bus_cycle("R5 wait 7", 2'b01, 1'b0, 1'b1, 3'd7, 0, 13);
        bus_cycle("R5 wait 1", 2'b00, 1'b0, 1'b1, 3'd1, 0, 6);
        bus_cycle("R6 end during wait", 2'b10, 1'b1, 1'b1, 3'd7, 0, 4);
        bus_cycle("R10 write late ds", 2'b10, 1'b0, 1'b0, 3'd0, 5, 10);
        bus_cycle("R10 write late ds with wait", 2'b01, 1'b1, 1'b0, 3'd2, 4, 10);
        bus_cycle("R6 long hold", 2'b10, 1'b1, 1'b1, 3'd0, 0, 20);

        // R10: write with data strobe never asserted stays in wait
        cur_tag = "R10";
        width_cfg = 2'b10; a4 = 1'b1; rw = 1'b0; wait_cfg = 3'd0;
        tick(1);
        cs_n = 1'b0; as_n = 1'b0;
        tick(8);
        check("R10 write held in wait", {30'd0, ack_n}, 32'd3);
        as_n = 1'b1; cs_n = 1'b1; rw = 1'b1;
        tick(6);

        // second reset restores register values
        rst_n = 1'b0;
        tick(4);
        rf_raddr = 4'd3; #1;
        check("R8 data after second reset", rf_rdata, 32'h7FC0_0000);
        rf_raddr = 4'd10; #1;
        check("R8 iaddr after second reset", rf_rdata, 32'h0);
        rf_we = 1'b1; rf_waddr = 4'd9; rf_wdata = 32'hDEAD;
        tick(1);
        rf_we = 1'b0; rf_raddr = 4'd9; #1;
        check("R9 write ignored in reset", rf_rdata, 32'h0);
        rst_n = 1'b1;
        tick(3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule